// File: doc/BRIEF.md
# Byte-Parity Protected SRAM Wrapper

This block wraps a synchronous, word-addressed RAM and widens every stored word by one parity bit per data byte, so a 32-bit word occupies 36 storage bits. A single access port accepts byte, half-word and word writes through per-byte strobes. Each enabled byte is written together with its freshly computed even-parity bit. Strobed-off bytes keep both their data and their parity untouched.

A read returns the whole word one cycle after the request. In that same cycle, the parity of the bytes named by the read strobes is checked. When checking is enabled, a mismatch in any checked byte drives a one-cycle non-maskable interrupt request and sets a sticky error flag. Software clears the flag by pulsing a clear input. A lock control, once set, stays set until reset and also routes each error pulse to a break output intended for timer break inputs.

A parity-inversion input on the write path stores deliberately wrong parity for the enabled bytes. This is how error handling is exercised.

Top module: `bytepar_ram`

## Requirements
- R1: A write stores `acc_wdata` byte lane i (bits 8i+7..8i) only when `acc_be[i]` is 1; a later read of the same address returns the stored word on `rd_data`, with unstrobed lanes holding their earlier contents.
- R2: A read request (`acc_req`=1, `acc_we`=0) sampled at a clock edge makes `rd_valid` 1 for exactly the following cycle, with `rd_data` valid in that cycle; writes and idle cycles leave `rd_valid` at 0.
- R3: Each written byte stores even parity (the XOR of its eight bits), so reading back bytes written with `inj_par_flip` at 0 never raises an error, including after mixed partial writes.
- R4: A write with `inj_par_flip[i]`=1 and `acc_be[i]`=1 stores the inverted parity for lane i, so that lane later reads as a parity error.
- R5: In the `rd_valid` cycle, `nmi_req` is 1 exactly when `chk_en` is 1 and at least one lane whose read strobe was 1 holds bad parity; bad lanes that were not strobed are ignored.
- R6: While `chk_en` is 0, no read raises `nmi_req`, `brk_out` or `err_sticky`.
- R7: `err_sticky` becomes 1 at the clock edge that ends an `nmi_req` cycle and stays 1 until an edge with `err_clr`=1 and no `nmi_req`; when an error and a clear occur together, the error wins.
- R8: `lock_on` becomes 1 at the edge after `lock_set` is sampled and stays 1 until reset; `brk_out` equals `nmi_req` while `lock_on` is 1 and is 0 otherwise.
- R9: After reset, `rd_valid`, `nmi_req`, `err_sticky`, `lock_on` and `brk_out` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| acc_req | input | 1 | Access request for this cycle |
| acc_we | input | 1 | 1 = write, 0 = read |
| acc_addr | input | ADDR_W | Word address |
| acc_be | input | DATA_W/8 | Byte strobes; lane i covers data bits 8i+7..8i |
| acc_wdata | input | DATA_W | Write data |
| inj_par_flip | input | DATA_W/8 | Per-lane inversion of the stored parity on write |
| chk_en | input | 1 | Enables parity error reporting |
| err_clr | input | 1 | Clears the sticky error flag |
| lock_set | input | 1 | Sets the break-routing lock |
| rd_valid | output | 1 | Read data valid |
| rd_data | output | DATA_W | Read data |
| nmi_req | output | 1 | One-cycle interrupt request per failing read |
| err_sticky | output | 1 | Sticky parity error flag |
| lock_on | output | 1 | Lock state |
| brk_out | output | 1 | Error routed to the break line |

## Verification
The bench builds the block with ADDR_W=4 and the default 32-bit data width. With only sixteen words, random traffic keeps returning to the same locations. Partial writes therefore land on words that already hold injected bad parity, which brings within reach the cases where a strobed rewrite repairs one lane while a neighbouring bad lane survives. It also brings within reach reads whose strobes step around a bad lane.

// File: rtl/bytepar_ram_pkg.sv
package bytepar_ram_pkg;
  // Decoded access kind for the current request.
  typedef enum logic [1:0] {
    ACC_IDLE  = 2'd0,
    ACC_READ  = 2'd1,
    ACC_WRITE = 2'd2
  } acc_kind_e;

  localparam int unsigned LANE_BITS = 8;

  function automatic logic even_par8(input logic [LANE_BITS-1:0] b);
    return ^b;
  endfunction
endpackage

// File: rtl/bytepar_pgen.sv
module bytepar_pgen #(
  parameter int unsigned NB = 4
) (
  input  logic [NB*8-1:0] data,
  input  logic [NB-1:0]   flip,
  output logic [NB-1:0]   par
);
  import bytepar_ram_pkg::*;

  for (genvar i = 0; i < NB; i++) begin : g_lane
    always_comb begin
      par[i] = even_par8(data[i*LANE_BITS +: LANE_BITS]) ^ flip[i];
    end
  end
endmodule

// File: rtl/bytepar_array.sv
module bytepar_array #(
  parameter int unsigned ADDR_W = 6,
  parameter int unsigned NB     = 4
) (
  input  logic              clk,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [NB-1:0]     be,
  input  logic [NB*8-1:0]   wdata,
  input  logic [NB-1:0]     wpar,
  output logic [NB*8-1:0]   rdata_q,
  output logic [NB-1:0]     rpar_q
);
  localparam int unsigned DEPTH  = 1 << ADDR_W;
  localparam int unsigned LANE_W = 9;

  // One 9-bit-wide memory per byte lane: 8 data bits plus parity.
  for (genvar i = 0; i < NB; i++) begin : g_lane
    logic [LANE_W-1:0] lane_mem [DEPTH];
    logic              lane_we;
    logic [LANE_W-1:0] lane_rd_q;

    always_comb begin
      lane_we = wr_en & be[i];
    end

    always_ff @(posedge clk) begin
      if (lane_we) begin
        lane_mem[addr] <= {wpar[i], wdata[i*8 +: 8]};
      end
    end

    always_ff @(posedge clk) begin
      if (rd_en) begin
        lane_rd_q <= lane_mem[addr];
      end
    end

    always_comb begin
      rdata_q[i*8 +: 8] = lane_rd_q[7:0];
      rpar_q[i]         = lane_rd_q[8];
    end
  end
endmodule

// File: rtl/bytepar_pchk.sv
module bytepar_pchk #(
  parameter int unsigned NB = 4
) (
  input  logic            rd_valid,
  input  logic            chk_en,
  input  logic [NB*8-1:0] rdata,
  input  logic [NB-1:0]   rpar,
  input  logic [NB-1:0]   rd_be,
  output logic            err
);
  import bytepar_ram_pkg::*;

  logic [NB-1:0] lane_bad;

  for (genvar i = 0; i < NB; i++) begin : g_lane
    always_comb begin
      lane_bad[i] = (even_par8(rdata[i*LANE_BITS +: LANE_BITS]) != rpar[i]) & rd_be[i];
    end
  end

  always_comb begin
    err = rd_valid & chk_en & (|lane_bad);
  end
endmodule

// File: rtl/bytepar_errctl.sv
module bytepar_errctl (
  input  logic clk,
  input  logic rst_n,
  input  logic err,
  input  logic clr,
  input  logic lock_set,
  output logic flag_q,
  output logic lock_q
);
  logic flag_d, flag_en;
  logic lock_d, lock_en;

  always_comb begin
    flag_en = err | clr;
    flag_d  = err;          // error has priority over clear
    lock_en = lock_set & ~lock_q;
    lock_d  = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q <= 1'b0;
      lock_q <= 1'b0;
    end else begin
      if (flag_en) flag_q <= flag_d;
      if (lock_en) lock_q <= lock_d;
    end
  end
endmodule

// File: rtl/bytepar_ram.sv
module bytepar_ram #(
  parameter int unsigned ADDR_W = 6,
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              acc_req,
  input  logic              acc_we,
  input  logic [ADDR_W-1:0] acc_addr,
  input  logic [DATA_W/8-1:0] acc_be,
  input  logic [DATA_W-1:0] acc_wdata,
  input  logic [DATA_W/8-1:0] inj_par_flip,
  input  logic              chk_en,
  input  logic              err_clr,
  input  logic              lock_set,
  output logic              rd_valid,
  output logic [DATA_W-1:0] rd_data,
  output logic              nmi_req,
  output logic              err_sticky,
  output logic              lock_on,
  output logic              brk_out
);
  import bytepar_ram_pkg::*;

  localparam int unsigned NB = DATA_W / 8;

  // Reset: asserted asynchronously, released on the clock.
  logic [1:0] rst_sync_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end

  always_comb rst_int_n = rst_sync_q[1];

  // Access decode.
  acc_kind_e kind;
  logic      wr_en, rd_en;

  always_comb begin
    if (!acc_req)    kind = ACC_IDLE;
    else if (acc_we) kind = ACC_WRITE;
    else             kind = ACC_READ;
    wr_en = (kind == ACC_WRITE);
    rd_en = (kind == ACC_READ);
  end

  // Parity generation on the write path.
  logic [NB-1:0] wpar;

  bytepar_pgen #(.NB(NB)) pgen_i (
    .data (acc_wdata),
    .flip (inj_par_flip),
    .par  (wpar)
  );

  // Storage.
  logic [DATA_W-1:0] arr_rdata;
  logic [NB-1:0]     arr_rpar;

  bytepar_array #(.ADDR_W(ADDR_W), .NB(NB)) array_i (
    .clk     (clk),
    .wr_en   (wr_en),
    .rd_en   (rd_en),
    .addr    (acc_addr),
    .be      (acc_be),
    .wdata   (acc_wdata),
    .wpar    (wpar),
    .rdata_q (arr_rdata),
    .rpar_q  (arr_rpar)
  );

  // Read-side control registers.
  logic          rdv_d, rdv_q;
  logic [NB-1:0] rbe_d, rbe_q;
  logic          rbe_en;

  always_comb begin
    rdv_d  = rd_en;
    rbe_en = rd_en;
    rbe_d  = acc_be;
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      rdv_q <= 1'b0;
      rbe_q <= '0;
    end else begin
      rdv_q <= rdv_d;
      if (rbe_en) rbe_q <= rbe_d;
    end
  end

  // Parity check of the strobed lanes.
  logic par_err;

  bytepar_pchk #(.NB(NB)) pchk_i (
    .rd_valid (rdv_q),
    .chk_en   (chk_en),
    .rdata    (arr_rdata),
    .rpar     (arr_rpar),
    .rd_be    (rbe_q),
    .err      (par_err)
  );

  // Error flag and lock.
  logic flag_q, lock_q;

  bytepar_errctl errctl_i (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .err      (par_err),
    .clr      (err_clr),
    .lock_set (lock_set),
    .flag_q   (flag_q),
    .lock_q   (lock_q)
  );

  always_comb begin
    rd_valid   = rdv_q;
    rd_data    = arr_rdata;
    nmi_req    = par_err;
    err_sticky = flag_q;
    lock_on    = lock_q;
    brk_out    = par_err & lock_q;
  end
endmodule

// File: rtl/bytepar_ram_chk.sv
module bytepar_ram_chk (
  input logic clk,
  input logic rst_n,
  input logic acc_req,
  input logic acc_we,
  input logic chk_en,
  input logic err_clr,
  input logic rd_valid,
  input logic nmi_req,
  input logic err_sticky,
  input logic lock_on,
  input logic brk_out
);
  // R2: a valid read cycle follows a read request
  p_rdv_after_read_r2: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> $past(acc_req && !acc_we));

  // R5: an interrupt request only accompanies read data
  p_nmi_with_data_r5: assert property (@(posedge clk) disable iff (!rst_n)
    nmi_req |-> rd_valid);

  // R6: no request while checking is off
  p_nmi_gated_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !chk_en |-> !nmi_req);

  // R7: error sets the flag at the next edge
  p_flag_set_r7: assert property (@(posedge clk) disable iff (!rst_n)
    nmi_req |=> err_sticky);

  // R7: flag holds without a clear
  p_flag_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (err_sticky && !err_clr) |=> err_sticky);

  // R7: clear without an error drops the flag
  p_flag_clr_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (err_clr && !nmi_req) |=> !err_sticky);

  // R8: lock never falls outside reset
  p_lock_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    lock_on |=> lock_on);

  // R8: break only under lock and with an error
  p_brk_needs_lock_r8: assert property (@(posedge clk) disable iff (!rst_n)
    brk_out |-> (lock_on && nmi_req));

  // R8: with lock set, every error reaches the break line
  p_brk_follows_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (lock_on && nmi_req) |-> brk_out);
endmodule

bind bytepar_ram bytepar_ram_chk chk_i (
  .clk        (clk),
  .rst_n      (rst_n),
  .acc_req    (acc_req),
  .acc_we     (acc_we),
  .chk_en     (chk_en),
  .err_clr    (err_clr),
  .rd_valid   (rd_valid),
  .nmi_req    (nmi_req),
  .err_sticky (err_sticky),
  .lock_on    (lock_on),
  .brk_out    (brk_out)
);

// File: tb/bytepar_ram_tb_top.sv
`timescale 1ns/1ps
module bytepar_ram_tb_top;
  localparam int unsigned AW = 4;
  localparam int unsigned DW = 32;
  localparam int unsigned NW = 1 << AW;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          acc_req = 1'b0, acc_we = 1'b0;
  logic [AW-1:0] acc_addr = '0;
  logic [3:0]    acc_be = '0;
  logic [DW-1:0] acc_wdata = '0;
  logic [3:0]    inj_par_flip = '0;
  logic          chk_en = 1'b0, err_clr = 1'b0, lock_set = 1'b0;
  logic          rd_valid, nmi_req, err_sticky, lock_on, brk_out;
  logic [DW-1:0] rd_data;

  always #5 clk = ~clk;

  bytepar_ram #(.ADDR_W(AW), .DATA_W(DW)) dut_i (
    .clk(clk), .rst_n(rst_n), .acc_req(acc_req), .acc_we(acc_we),
    .acc_addr(acc_addr), .acc_be(acc_be), .acc_wdata(acc_wdata),
    .inj_par_flip(inj_par_flip), .chk_en(chk_en), .err_clr(err_clr),
    .lock_set(lock_set), .rd_valid(rd_valid), .rd_data(rd_data),
    .nmi_req(nmi_req), .err_sticky(err_sticky), .lock_on(lock_on),
    .brk_out(brk_out)
  );

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  // Reference model.
  logic [31:0] m_d   [NW];
  logic [3:0]  m_bad [NW];
  bit          m_flag = 0, m_lock = 0;
  bit          p_rd = 0;
  logic [31:0] p_d = '0;
  logic [3:0]  p_bad = '0, p_be = '0;
  bit          cur_ce = 0;

  function automatic bit exp_err(bit rd, bit ce, logic [3:0] bad, logic [3:0] be);
    return rd && ce && ((bad & be) != 4'b0);
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // One clock cycle: check what the previous cycle produced, then drive
  // the new inputs and advance the model across the coming edge.
  task automatic cyc(input bit rq, input bit we, input logic [AW-1:0] a,
                     input logic [3:0] be, input logic [31:0] wd,
                     input logic [3:0] fl, input bit ce, input bit cl, input bit lk);
    bit e_now, e_edge;
    e_now = exp_err(p_rd, cur_ce, p_bad, p_be);
    chk("R2 rd_valid", {31'b0, rd_valid}, {31'b0, p_rd});
    if (p_rd) chk("R1 rd_data", rd_data, p_d);
    chk("R3/R5/R6 nmi_req", {31'b0, nmi_req}, {31'b0, e_now});
    chk("R7 err_sticky", {31'b0, err_sticky}, {31'b0, m_flag});
    chk("R8 lock_on", {31'b0, lock_on}, {31'b0, m_lock});
    chk("R8 brk_out", {31'b0, brk_out}, {31'b0, e_now && m_lock});

    acc_req = rq; acc_we = we; acc_addr = a; acc_be = be; acc_wdata = wd;
    inj_par_flip = fl; chk_en = ce; err_clr = cl; lock_set = lk;
    cur_ce = ce;

    e_edge = exp_err(p_rd, ce, p_bad, p_be);
    if (e_edge) m_flag = 1;
    else if (cl) m_flag = 0;
    if (lk) m_lock = 1;
    p_rd = rq && !we;
    if (p_rd) begin
      p_d = m_d[a]; p_bad = m_bad[a]; p_be = be;
    end
    if (rq && we) begin
      for (int i = 0; i < 4; i++) begin
        if (be[i]) begin
          m_d[a][i*8 +: 8] = wd[i*8 +: 8];
          m_bad[a][i] = fl[i];
        end
      end
    end
    @(negedge clk);
  endtask

  task automatic idle(input bit ce);
    cyc(0, 0, '0, '0, '0, '0, ce, 0, 0);
  endtask

  function automatic logic [3:0] pick_be(input int unsigned r);
    case (r % 7)
      0: return 4'b0001; 1: return 4'b0010; 2: return 4'b0100; 3: return 4'b1000;
      4: return 4'b0011; 5: return 4'b1100; default: return 4'b1111;
    endcase
  endfunction

  initial begin
    for (int i = 0; i < NW; i++) begin m_d[i] = '0; m_bad[i] = '0; end
    repeat (3) @(negedge clk);
    // R9: reset state
    chk("R9 rd_valid", {31'b0, rd_valid}, 32'd0);
    chk("R9 nmi_req", {31'b0, nmi_req}, 32'd0);
    chk("R9 err_sticky", {31'b0, err_sticky}, 32'd0);
    chk("R9 lock_on", {31'b0, lock_on}, 32'd0);
    chk("R9 brk_out", {31'b0, brk_out}, 32'd0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // Initialise every word with good parity (R3).
    for (int i = 0; i < NW; i++) cyc(1, 1, AW'(i), 4'hF, 32'h1000_0000 + i * 32'h0101_0303, 4'h0, 1, 0, 0);

    // R1: half-word write keeps the other half; R3: no error on readback.
    cyc(1, 1, 4'd2, 4'b1100, 32'hABCD_0000, 4'h0, 1, 0, 0);
    cyc(1, 0, 4'd2, 4'hF, '0, '0, 1, 0, 0);
    idle(1);

    // R4: flip lane 1 parity of word 5; R5: read skipping lane 1 gives no error.
    cyc(1, 1, 4'd5, 4'b0010, 32'h0000_5A00, 4'b0010, 1, 0, 0);
    cyc(1, 0, 4'd5, 4'b1101, '0, '0, 1, 0, 0);
    idle(1);
    // R5: read including lane 1 raises the request, flag follows (R7).
    cyc(1, 0, 4'd5, 4'b0010, '0, '0, 1, 0, 0);
    idle(1);
    idle(1);
    // R7: plain clear drops the flag.
    cyc(0, 0, '0, '0, '0, '0, 1, 1, 0);
    idle(1);
    // R6: checking off, bad lane read, no error and no flag.
    cyc(1, 0, 4'd5, 4'hF, '0, '0, 0, 0, 0);
    idle(0);
    idle(0);
    // R7: error and clear on the same edge, error wins.
    cyc(1, 0, 4'd5, 4'hF, '0, '0, 1, 0, 0);
    cyc(0, 0, '0, '0, '0, '0, 1, 1, 0);
    idle(1);
    cyc(0, 0, '0, '0, '0, '0, 1, 1, 0);
    // R8: lock set, then error reaches break line.
    cyc(0, 0, '0, '0, '0, '0, 1, 0, 1);
    cyc(1, 0, 4'd5, 4'b0011, '0, '0, 1, 0, 0);
    idle(1);
    // R4/R3: rewriting the bad lane with good parity repairs it.
    cyc(1, 1, 4'd5, 4'b0010, 32'h0000_7700, 4'h0, 1, 0, 0);
    cyc(1, 0, 4'd5, 4'hF, '0, '0, 1, 1, 0);
    idle(1);

    // Constrained random traffic with a fixed seed.
    void'($urandom(32'd20240611));
    for (int n = 0; n < 3000; n++) begin
      int unsigned r1, r2;
      bit rq, we, ce, cl;
      logic [3:0] fl;
      r1 = $urandom; r2 = $urandom;
      rq = (r1 % 10) < 8;
      we = ((r1 >> 4) % 10) < 4;
      fl = (((r1 >> 8) % 8) == 0) ? 4'($urandom) : 4'h0;
      ce = ((n / 200) % 4) != 3;
      cl = ((r1 >> 12) % 16) == 0;
      cyc(rq, we, AW'(r2), pick_be(r2 >> 8), $urandom, fl, ce, cl, 0);
    end
    idle(1);
    idle(1);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule